// File: doc/BRIEF.md
# Serial Port Interrupt Register Group

This block holds the interrupt bookkeeping registers of a serial peripheral. Condition signals from the serial core are folded into a status register. The mode-fault pulse and the transmit low-watermark crossing are latched and stay set until software writes 1 to them. The transmit-full and receive-not-empty indications follow the FIFO levels live. A seven-bit interrupt mask is changed only through two write-only registers: one sets mask bits and the other clears them. The mask is read back through its own read-only register. A single interrupt line is raised when any status bit is set and its mask bit is also set.

Software reaches the registers through a plain register port. Writes are qualified by a strobe and a byte offset. Reads are combinational from a separate read offset. The transmit watermark threshold lives in a small register of its own in the same group. The core supplies the mode-fault pulse and the current TX and RX FIFO fill levels.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the latched status bits are 0, the mask is 0, the interrupt output is 0 and the watermark threshold reads back as 1.
- R2: The byte offsets are 0x04 for status, 0x08 for mask-set, 0x0C for mask-clear, 0x10 for mask readback and 0x28 for the watermark threshold (bits 7:0). Reads of 0x08, 0x0C and any unmapped offset return 0.
- R3: Writing to 0x08 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged; the change is visible one clock edge after the write.
- R4: Writing to 0x0C clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged; the change is visible one clock edge after the write.
- R5: Status bit 1 (mode fault) becomes 1 at the edge that samples a high mode-fault input. Writing 1 to bit 1 at 0x04 clears it, and writing 0 leaves it unchanged.
- R6: Status bit 2 (TX low watermark) becomes 1 at the edge after the TX level goes from at or above the threshold to below it. It then stays set until cleared by writing 1. While the level stays below the threshold, the bit does not set again. A level already below the threshold when reset is released does not set it.
- R7: Status bit 3 is 1 exactly when the TX level equals the FIFO depth (128). Status bit 4 is 1 exactly when the RX level is nonzero. Both follow the levels in the same cycle, and writing 1 to them has no effect.
- R8: When a set event for a latched bit arrives in the same cycle as a write-1 clear of that bit, the bit stays 1.
- R9: The interrupt output is registered. After each clock edge it equals the OR of (status AND mask) as the two stood just before that edge.
- R10: Status bits 0, 5 and 6 read 0. All seven mask bits are writable. Data bits above bit 6 in writes to 0x04, 0x08 and 0x0C are ignored, and mask readback bits above bit 6 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| mode_fault | input | 1 | Mode-fault event pulse from the core |
| tx_level | input | LVL_W | Current TX FIFO fill level |
| rx_level | input | LVL_W | Current RX FIFO fill level |
| irq | output | 1 | Registered interrupt request |

## Verification
A latched status bit or a mask change is due on the read port one clock edge after the stimulus that caused it. The live FIFO bits are due in the same cycle as the level that drives them. The interrupt line trails the status and mask it reflects by one further edge. The bench changes every input on the falling edge and lets exactly one rising edge pass. It then compares the read port and the interrupt against a cycle model at the next falling edge, before it changes anything again. For each check, the model predicts the interrupt from the status and mask as they stood before that edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   // Register group geometry
   localparam int IRQ_W    = 7;
   localparam int ADDR_MAX = 16;

   // Byte offsets (decoded by software, so fixed)
   localparam logic [ADDR_MAX-1:0] OFS_STAT  = 16'h0004;
   localparam logic [ADDR_MAX-1:0] OFS_SET   = 16'h0008;
   localparam logic [ADDR_MAX-1:0] OFS_CLR   = 16'h000C;
   localparam logic [ADDR_MAX-1:0] OFS_MASK  = 16'h0010;
   localparam logic [ADDR_MAX-1:0] OFS_WMARK = 16'h0028;

   // Status bit positions
   localparam int B_MODF   = 1;
   localparam int B_TXLOW  = 2;
   localparam int B_TXFULL = 3;
   localparam int B_RXNE   = 4;

   // Which bits hold an event and which follow a level
   localparam logic [IRQ_W-1:0] LATCH_BITS = 7'b000_0110;
   localparam logic [IRQ_W-1:0] LIVE_BITS  = 7'b001_1000;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_SET,
      SEL_CLR,
      SEL_MASK,
      SEL_WMARK
   } reg_sel_e;

   function automatic reg_sel_e sel_of(input logic [ADDR_MAX-1:0] a);
      case (a)
         OFS_STAT:  return SEL_STAT;
         OFS_SET:   return SEL_SET;
         OFS_CLR:   return SEL_CLR;
         OFS_MASK:  return SEL_MASK;
         OFS_WMARK: return SEL_WMARK;
         default:   return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/spi_irq_stat_bank.sv
module spi_irq_stat_bank #(
   parameter int               NBITS = 7,
   parameter logic [NBITS-1:0] LATCH = '0,
   parameter logic [NBITS-1:0] LIVE  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic [NBITS-1:0] clr_i,
   input  logic [NBITS-1:0] live_i,
   output logic [NBITS-1:0] stat_o
);

   initial begin : p_param_chk
      assert ((LATCH & LIVE) == '0)
         else $fatal(1, "a status bit cannot be both latched and live");
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      if (LATCH[i]) begin : g_latch
         logic bit_q;
         logic unused_live;
         assign unused_live = live_i[i];
         always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;   // event wins over clear
            else if (clr_i[i]) bit_q <= 1'b0;
         end
         assign stat_o[i] = bit_q;
      end else if (LIVE[i]) begin : g_live
         logic unused_sc;
         assign unused_sc = set_i[i] ^ clr_i[i];
         assign stat_o[i] = live_i[i];
      end else begin : g_rsvd
         logic unused_all;
         assign unused_all = set_i[i] ^ clr_i[i] ^ live_i[i];
         assign stat_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/spi_irq_mask_reg.sv
module spi_irq_mask_reg #(
   parameter int NBITS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [NBITS-1:0] wbits,
   output logic [NBITS-1:0] mask_o
);

   logic [NBITS-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= '0;
      else if (set_we) mask_q <= mask_q | wbits;
      else if (clr_we) mask_q <= mask_q & ~wbits;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/spi_irq_wmark.sv
module spi_irq_wmark #(
   parameter int LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [LVL_W-1:0] wdata,
   input  logic [LVL_W-1:0] tx_level,
   output logic [LVL_W-1:0] thresh_o,
   output logic             fall_o
);

   logic [LVL_W-1:0] thresh_q;
   logic             below_q;
   logic             below;

   assign below = tx_level < thresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thresh_q <= LVL_W'(1);
         below_q  <= 1'b1;          // no event for a level already low at reset
      end else begin
         below_q <= below;
         if (we) thresh_q <= wdata;
      end
   end

   assign thresh_o = thresh_q;
   assign fall_o   = below & ~below_q;

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int LVL_W      = 8,
   parameter int FIFO_DEPTH = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              mode_fault,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic [LVL_W-1:0]  rx_level,
   output logic              irq
);

   import spi_irq_pkg::*;

   localparam int NB = IRQ_W;

   initial begin : p_param_chk
      assert (DATA_W >= NB && DATA_W >= LVL_W)
         else $fatal(1, "DATA_W too narrow for the register fields");
      assert (ADDR_W >= 6 && ADDR_W <= ADDR_MAX)
         else $fatal(1, "ADDR_W cannot hold the register offsets");
      assert (FIFO_DEPTH > 0 && FIFO_DEPTH < (1 << LVL_W))
         else $fatal(1, "LVL_W cannot represent FIFO_DEPTH");
   end

   reg_sel_e         wr_sel, rd_sel;
   logic [NB-1:0]    stat_w, mask_w, set_v, clr_v, live_v;
   logic [LVL_W-1:0] thresh_w;
   logic             fall_w;
   logic             irq_q;
   logic             unused_wdata;

   assign wr_sel       = wr_en ? sel_of(ADDR_MAX'(wr_addr)) : SEL_NONE;
   assign rd_sel       = sel_of(ADDR_MAX'(rd_addr));
   assign unused_wdata = ^wr_data;

   always_comb begin
      set_v            = '0;
      set_v[B_MODF]    = mode_fault;
      set_v[B_TXLOW]   = fall_w;
      live_v           = '0;
      live_v[B_TXFULL] = (tx_level == LVL_W'(FIFO_DEPTH));
      live_v[B_RXNE]   = |rx_level;
      clr_v            = (wr_sel == SEL_STAT) ? wr_data[NB-1:0] : '0;
   end

   spi_irq_wmark #(.LVL_W(LVL_W)) u_wmark (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_sel == SEL_WMARK),
      .wdata    (wr_data[LVL_W-1:0]),
      .tx_level (tx_level),
      .thresh_o (thresh_w),
      .fall_o   (fall_w)
   );

   spi_irq_stat_bank #(
      .NBITS (NB),
      .LATCH (LATCH_BITS),
      .LIVE  (LIVE_BITS)
   ) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .live_i (live_v),
      .stat_o (stat_w)
   );

   spi_irq_mask_reg #(.NBITS(NB)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_sel == SEL_SET),
      .clr_we (wr_sel == SEL_CLR),
      .wbits  (wr_data[NB-1:0]),
      .mask_o (mask_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_w & mask_w);
   end
   assign irq = irq_q;

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_STAT:  rd_data[NB-1:0]    = stat_w;
         SEL_MASK:  rd_data[NB-1:0]    = mask_w;
         SEL_WMARK: rd_data[LVL_W-1:0] = thresh_w;
         default:   rd_data            = '0;
      endcase
   end

endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk #(
   parameter int ADDR_W     = 8,
   parameter int LVL_W      = 8,
   parameter int FIFO_DEPTH = 128
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [ADDR_W-1:0]             wr_addr,
   input logic [spi_irq_pkg::IRQ_W-1:0] wr_bits,
   input logic                          mode_fault,
   input logic [LVL_W-1:0]              tx_level,
   input logic [LVL_W-1:0]              rx_level,
   input logic [spi_irq_pkg::IRQ_W-1:0] stat,
   input logic [spi_irq_pkg::IRQ_W-1:0] mask,
   input logic                          irq
);

   import spi_irq_pkg::*;

   logic wr_set, wr_clr, wr_stat;
   assign wr_set  = wr_en && (wr_addr == ADDR_W'(OFS_SET));
   assign wr_clr  = wr_en && (wr_addr == ADDR_W'(OFS_CLR));
   assign wr_stat = wr_en && (wr_addr == ADDR_W'(OFS_STAT));

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((mask & $past(wr_bits)) == $past(wr_bits)));              // R3

   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((mask & $past(wr_bits)) == '0));                          // R4

   AST_MODF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wr_bits[B_MODF] && !mode_fault) |=> !stat[B_MODF]);      // R5

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault |=> stat[B_MODF]);                                         // R8

   AST_RXNE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      stat[B_RXNE] == (rx_level != '0));                                    // R7

   AST_TXFULL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      stat[B_TXFULL] == (tx_level == LVL_W'(FIFO_DEPTH)));                  // R7

   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (irq == $past(|(stat & mask))));                           // R9

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[0] == 1'b0) && (stat[6:5] == 2'b00));                           // R10

endmodule

bind spi_irq_regs spi_irq_regs_chk #(
   .ADDR_W     (ADDR_W),
   .LVL_W      (LVL_W),
   .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_bits    (wr_data[spi_irq_pkg::IRQ_W-1:0]),
   .mode_fault (mode_fault),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .stat       (stat_w),
   .mask       (mask_w),
   .irq        (irq)
);

// File: tb/spi_irq_regs_test.sv
module spi_irq_regs_test;

   localparam int AW    = 8;
   localparam int DW    = 32;
   localparam int LW    = 8;
   localparam int DEPTH = 128;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [DW-1:0] wr_data, rd_data;
   logic          mode_fault;
   logic [LW-1:0] tx_level, rx_level;
   logic          irq;

   always #10 clk = ~clk;   // 50 MHz

   spi_irq_regs #(.ADDR_W(AW), .DATA_W(DW), .LVL_W(LW), .FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .mode_fault(mode_fault), .tx_level(tx_level), .rx_level(rx_level),
      .irq(irq)
   );

   int n_chk = 0;
   int n_bad = 0;

   // cycle model
   logic [6:0]    m_mask;
   logic          m_modf, m_low, m_prev, m_irq;
   logic [LW-1:0] m_wm;

   function automatic logic [6:0] vis(input logic [LW-1:0] tx, input logic [LW-1:0] rx,
                                      input logic modf, input logic low);
      return {2'b00, rx != 0, tx == LW'(DEPTH), low, modf, 1'b0};
   endfunction

   function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
      case (a)
         8'h04:   return 32'(vis(tx_level, rx_level, m_modf, m_low));
         8'h10:   return 32'(m_mask);
         8'h28:   return 32'(m_wm);
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic mf, input logic [LW-1:0] tx, input logic [LW-1:0] rx,
                        input logic [AW-1:0] ra);
      wr_en = we; wr_addr = wa; wr_data = wd;
      mode_fault = mf; tx_level = tx; rx_level = rx; rd_addr = ra;
   endtask

   // one rising edge; model advanced, read port and irq compared afterwards
   task automatic step(input string tag);
      logic [6:0] v_old, clr;
      logic       cond;
      v_old = vis(tx_level, rx_level, m_modf, m_low);
      clr   = (wr_en && wr_addr == 8'h04) ? wr_data[6:0] : 7'h0;
      cond  = tx_level < m_wm;
      m_irq = |(v_old & m_mask);
      m_modf = mode_fault | (m_modf & ~clr[1]);
      m_low  = (cond & ~m_prev) | (m_low & ~clr[2]);
      m_prev = cond;
      if (wr_en && wr_addr == 8'h08) m_mask = m_mask | wr_data[6:0];
      if (wr_en && wr_addr == 8'h0C) m_mask = m_mask & ~wr_data[6:0];
      if (wr_en && wr_addr == 8'h28) m_wm   = wr_data[LW-1:0];
      @(posedge clk);
      @(negedge clk);
      check({tag, " read"}, rd_data, exp_rd(rd_addr));
      check({tag, " irq R9"}, 32'(irq), 32'(m_irq));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0;
      drive(1'b0, '0, '0, 1'b0, '0, '0, '0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_mask = '0; m_modf = 1'b0; m_low = 1'b0; m_prev = 1'b1; m_irq = 1'b0; m_wm = LW'(1);

      // R1 / R2 reset values at every offset
      rd_addr = 8'h04; #1 check("R1 status reset", rd_data, 32'h0);
      rd_addr = 8'h10; #1 check("R1 mask reset", rd_data, 32'h0);
      rd_addr = 8'h28; #1 check("R1 watermark reset", rd_data, 32'h1);
      rd_addr = 8'h08; #1 check("R2 set offset reads 0", rd_data, 32'h0);
      rd_addr = 8'h0C; #1 check("R2 clr offset reads 0", rd_data, 32'h0);
      check("R1 irq reset", 32'(irq), 32'h0);

      drive(1'b1, 8'h08, 32'hFFFF_FFFF, 1'b0, 8'd0, 8'd0, 8'h10);
      step("R3");
      check("R3 R10 mask all set", rd_data, 32'h7F);
      drive(1'b1, 8'h0C, 32'h0000_0055, 1'b0, 8'd0, 8'd0, 8'h10);
      step("R4");
      check("R4 mask partial clear", rd_data, 32'h2A);

      drive(1'b0, 8'h00, 32'h0, 1'b1, 8'd0, 8'd0, 8'h04);
      step("R5");
      check("R5 modf latched", rd_data, 32'h02);
      check("R9 irq not yet", 32'(irq), 32'h0);
      drive(1'b1, 8'h04, 32'h0000_007D, 1'b0, 8'd0, 8'd0, 8'h04);
      step("R5");
      check("R5 write 0 keeps bit", rd_data, 32'h02);
      check("R9 irq one edge later", 32'(irq), 32'h1);
      drive(1'b1, 8'h04, 32'h0000_0002, 1'b0, 8'd0, 8'd0, 8'h04);
      step("R5");
      check("R5 write 1 clears", rd_data, 32'h00);
      drive(1'b0, 8'h00, 32'h0, 1'b0, 8'd0, 8'd0, 8'h04);
      step("R9");
      check("R9 irq drops", 32'(irq), 32'h0);

      drive(1'b1, 8'h04, 32'h0000_0002, 1'b1, 8'd0, 8'd0, 8'h04);
      step("R8");
      check("R8 event beats clear", rd_data, 32'h02);
      drive(1'b1, 8'h04, 32'h0000_0002, 1'b0, 8'd0, 8'd0, 8'h04);
      step("R8");

      drive(1'b1, 8'h28, 32'h0000_0004, 1'b0, 8'd10, 8'd0, 8'h28);
      step("R6");
      check("R6 threshold written", rd_data, 32'h04);
      drive(1'b0, 8'h00, 32'h0, 1'b0, 8'd2, 8'd0, 8'h04);
      step("R6");
      check("R6 fall below latches", rd_data, 32'h04);
      drive(1'b1, 8'h04, 32'h0000_0004, 1'b0, 8'd2, 8'd0, 8'h04);
      step("R6");
      check("R6 cleared", rd_data, 32'h00);
      drive(1'b0, 8'h00, 32'h0, 1'b0, 8'd2, 8'd0, 8'h04);
      step("R6");
      check("R6 no reset while low", rd_data, 32'h00);

      drive(1'b1, 8'h04, 32'h0000_0010, 1'b0, 8'd2, 8'd3, 8'h04);
      step("R7");
      check("R7 rx not empty sticks", rd_data, 32'h10);
      drive(1'b1, 8'h04, 32'h0000_0008, 1'b0, 8'd128, 8'd3, 8'h04);
      step("R7");
      check("R7 tx full live", rd_data, 32'h18);
      drive(1'b0, 8'h00, 32'h0, 1'b0, 8'd127, 8'd0, 8'h04);
      #1 check("R7 levels drop same cycle", rd_data, 32'h00);
      step("R7");

      for (int n = 0; n < 4000; n++) begin
         logic [AW-1:0] wa, ra;
         logic [LW-1:0] tx;
         logic [DW-1:0] wd;
         case ($urandom % 7)
            0: wa = 8'h04; 1: wa = 8'h08; 2: wa = 8'h0C;
            3: wa = 8'h10; 4: wa = 8'h28; 5: wa = 8'h04;
            default: wa = AW'($urandom);
         endcase
         case ($urandom % 5)
            0: ra = 8'h10; 1: ra = 8'h28; 2: ra = AW'($urandom);
            default: ra = 8'h04;
         endcase
         case ($urandom % 4)
            0: tx = 8'd128; 1: tx = LW'($urandom % 8);
            default: tx = LW'($urandom % 129);
         endcase
         wd = $urandom;
         if (wa == 8'h28) wd[7:0] = 8'($urandom % 12);
         drive(($urandom % 2) == 0, wa, wd, ($urandom % 6) == 0, tx,
               (($urandom % 3) == 0) ? LW'($urandom) : '0, ra);
         step("random R2 R3 R4 R5 R6 R7 R10");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule